// File: doc/BRIEF.md
# Half-Duplex Transmit Status Tracker

This block sits beside an Ethernet MAC transmitter and follows each frame from its first attempt to its final outcome. It counts collisions across repeated attempts, measures each attempt against the collision window in byte-times, and decides after every collision whether the transmitter should try again or give up. It also watches carrier sense for missing or dropped carrier, and gathers a handful of per-frame condition flags.

When a frame completes or is abandoned, the block emits one packed 16-bit status word with a one-cycle valid strobe, then clears its per-frame state for the next frame. The status word and the retry/abort pulses are plain status outputs. They have no ready input and cannot be back-pressured, so the consumer must capture the word in the cycle in which `stat_valid` is high. Backoff timing, CRC generation, payload checks and descriptor handling belong to neighbouring logic.

A frame is active from the cycle after an accepted `tx_start` until it completes, aborts or receives a retry. All event and flag inputs are sampled only on active cycles. Configuration inputs are expected to stay constant for the length of a frame.

Top module: `txstat_tracker`

## Requirements
- R1: Status word layout: collision count in bits 6:3, VLAN in bit 7, excessive collision in bit 8, late collision in bit 9, no carrier in bit 10, loss of carrier in bit 11, IP payload error in bit 12, flushed in bit 13, jabber timeout in bit 14. Bits 15 and 2:0 are zero. `stat_valid` is high for exactly one cycle, in the cycle after the sampled `tx_end`. After reset all outputs are zero.
- R2: In half-duplex mode, the count field holds the number of collisions in the frame, including the one that aborted it, and saturates at 15. In full-duplex mode `coll` is ignored: the count stays 0 and no retry or abort occurs.
- R3: A collision inside the window, while the attempt limit has not been reached, raises `retry_o` for one cycle in the next cycle and emits no status. The collision count is kept, and the byte-time count restarts at the next `tx_start`.
- R4: The collision that brings the frame's collision total to ATTEMPT_LIMIT aborts the frame. In the next cycle `abort_o` and `stat_valid` are high together, with bit 8 set.
- R5: When `cfg_no_retry` is high, the first in-window collision aborts the frame with bit 8 set and a count of 1.
- R6: A collision sampled when WINDOW_BYTES or more `byte_tick` pulses have been seen on earlier active cycles of the attempt aborts the frame with bit 9 set and bit 8 clear. One tick fewer still counts as in-window.
- R7: If `underflow` was seen on any active cycle of the frame, bit 9 reads 0, but the abort still happens.
- R8: Bit 10 is set when `crs` was low on every active cycle of the frame.
- R9: Bit 11 is set when all of the following hold: the mode is half duplex, the frame saw no collision, and `crs` was low on some active cycle after it had been high on an earlier active cycle.
- R10: Bit 14 is set when `jabber` was seen during the frame and `cfg_jabber_off` is low.
- R11: Bits 7, 12 and 13 are set when `vlan`, `ip_err` and `flush` respectively were high on any active cycle of the frame.
- R12: Inputs on inactive cycles, and `tx_start` while a frame is active, have no effect. No per-frame flag carries into the next frame.
- R13: A counted collision and `tx_end` in the same cycle are handled as a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Start of an attempt (preamble begins) |
| tx_end | input | 1 | Attempt finished without collision |
| byte_tick | input | 1 | One pulse per transmitted byte-time |
| coll | input | 1 | Collision seen |
| crs | input | 1 | Carrier sense |
| underflow | input | 1 | Transmit data underflow |
| jabber | input | 1 | Jabber timer expired |
| vlan | input | 1 | Frame carries a VLAN tag |
| flush | input | 1 | Frame flushed on request |
| ip_err | input | 1 | Payload length mismatch reported |
| cfg_half_duplex | input | 1 | Half-duplex operation |
| cfg_no_retry | input | 1 | Give up on the first collision |
| cfg_jabber_off | input | 1 | Jabber timer disabled |
| retry_o | output | 1 | One-cycle pulse: retransmit the frame |
| abort_o | output | 1 | One-cycle pulse: frame abandoned |
| stat_word | output | 16 | Packed per-frame status |
| stat_valid | output | 1 | One-cycle pulse: `stat_word` is new |

## Verification
The bench builds the tracker with ATTEMPT_LIMIT at 16 and WINDOW_BYTES at 8. The short window lets late collisions, and the exact in-window/late boundary at 7 and 8 ticks, occur within a few cycles of each attempt. The full limit of 16 makes the 4-bit count saturate at 15 on the same collision that triggers the excessive abort. Random frames mix duplex modes, retry settings, carrier patterns and retry counts of up to 17 collisions around these directed edges.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  localparam int STAT_W = 16;
  localparam int CC_W   = 4;
  localparam int CC_LO  = 3;

  localparam int B_VLAN  = 7;
  localparam int B_EXC   = 8;
  localparam int B_LATE  = 9;
  localparam int B_NOCRS = 10;
  localparam int B_LOSS  = 11;
  localparam int B_IPE   = 12;
  localparam int B_FLUSH = 13;
  localparam int B_JAB   = 14;

  // indices of the sticky per-frame condition flags
  localparam int N_STICKY  = 5;
  localparam int STK_VLAN  = 0;
  localparam int STK_UND   = 1;
  localparam int STK_JAB   = 2;
  localparam int STK_FLUSH = 3;
  localparam int STK_IPE   = 4;

  typedef struct packed {
    logic [CC_W-1:0] cc;
    logic            vlan;
    logic            exc;
    logic            late;
    logic            nocrs;
    logic            loss;
    logic            ipe;
    logic            flush;
    logic            jab;
  } txstat_fields_t;

  function automatic logic [STAT_W-1:0] pack_status(input txstat_fields_t f);
    logic [STAT_W-1:0] w;
    w                 = '0;
    w[CC_LO +: CC_W]  = f.cc;
    w[B_VLAN]         = f.vlan;
    w[B_EXC]          = f.exc;
    w[B_LATE]         = f.late;
    w[B_NOCRS]        = f.nocrs;
    w[B_LOSS]         = f.loss;
    w[B_IPE]          = f.ipe;
    w[B_FLUSH]        = f.flush;
    w[B_JAB]          = f.jab;
    return w;
  endfunction

endpackage

// File: rtl/txstat_window.sv
// Byte-time counter for the current attempt; saturates at the window size.
module txstat_window #(
  parameter int WINDOW_BYTES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic tick,
  output logic beyond
);
  localparam int BW = $clog2(WINDOW_BYTES + 1);
  localparam logic [BW-1:0] WIN_V = BW'(WINDOW_BYTES);

  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (restart)                        cnt_q <= '0;
    else if (active && tick && cnt_q != WIN_V) cnt_q <= cnt_q + 1'b1;
  end

  assign beyond = (cnt_q == WIN_V);

endmodule

// File: rtl/txstat_coll.sv
// Collision accounting and the retry / give-up decision.
module txstat_coll #(
  parameter int ATTEMPT_LIMIT = 16,
  parameter int CNT_W         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             late_zone,
  input  logic             no_retry,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_now,
  output logic             exc_now,
  output logic             late_now,
  output logic             retry_now
);
  localparam int AW = $clog2(ATTEMPT_LIMIT + 1);
  localparam logic [AW:0] LIM_V = (AW+1)'(ATTEMPT_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic [AW-1:0]    att_q;
  logic [AW:0]      att_next;
  logic             give_up;

  always_comb begin
    cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    att_next  = {1'b0, att_q} + 1'b1;
    give_up   = no_retry || (att_next >= LIM_V);
    late_now  = hit && late_zone;
    exc_now   = hit && !late_zone && give_up;
    retry_now = hit && !late_zone && !give_up;
    cnt_now   = hit ? cnt_inc : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      att_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
      att_q <= '0;
    end else if (hit) begin
      cnt_q <= cnt_inc;
      att_q <= att_next[AW-1:0];
    end
  end

endmodule

// File: rtl/txstat_sticky.sv
// Per-frame sticky condition flags; outputs include the current cycle.
module txstat_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         clear,
  input  logic [N-1:0] ev,
  output logic [N-1:0] seen_now
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    assign seen_now[i] = q | (active & ev[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (clear) q <= 1'b0;
      else            q <= seen_now[i];
    end
  end
endmodule

// File: rtl/txstat_carrier.sv
// Carrier-sense history over the active cycles of a frame.
module txstat_carrier (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic clear,
  input  logic crs,
  output logic seen_now,
  output logic drop_now
);
  logic seen_q, drop_q;

  assign seen_now = seen_q | (active & crs);
  assign drop_now = drop_q | (active & !crs & seen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      drop_q <= 1'b0;
    end else if (clear) begin
      seen_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      seen_q <= seen_now;
      drop_q <= drop_now;
    end
  end
endmodule

// File: rtl/txstat_tracker.sv
module txstat_tracker
  import txstat_pkg::*;
#(
  parameter int ATTEMPT_LIMIT = 16,
  parameter int WINDOW_BYTES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic              tx_end,
  input  logic              byte_tick,
  input  logic              coll,
  input  logic              crs,
  input  logic              underflow,
  input  logic              jabber,
  input  logic              vlan,
  input  logic              flush,
  input  logic              ip_err,
  input  logic              cfg_half_duplex,
  input  logic              cfg_no_retry,
  input  logic              cfg_jabber_off,
  output logic              retry_o,
  output logic              abort_o,
  output logic [STAT_W-1:0] stat_word,
  output logic              stat_valid
);
  logic            active_q;
  logic            start_ok, hit, beyond;
  logic [CC_W-1:0] cnt_now;
  logic            exc_now, late_now, retry_now, abort_now, finish;
  logic [N_STICKY-1:0] ev, seen;
  logic            crs_seen, crs_drop;
  txstat_fields_t  fld;

  assign start_ok  = tx_start && !active_q;
  assign hit       = active_q && coll && cfg_half_duplex;
  assign abort_now = exc_now || late_now;
  // a counted collision takes precedence over a same-cycle end of frame
  assign finish    = abort_now || (active_q && tx_end && !hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      active_q <= 1'b0;
    else if (start_ok)               active_q <= 1'b1;
    else if (finish || retry_now)    active_q <= 1'b0;
  end

  txstat_window #(.WINDOW_BYTES(WINDOW_BYTES)) u_win (
    .clk(clk), .rst_n(rst_n), .restart(start_ok), .active(active_q),
    .tick(byte_tick), .beyond(beyond)
  );

  txstat_coll #(.ATTEMPT_LIMIT(ATTEMPT_LIMIT), .CNT_W(CC_W)) u_coll (
    .clk(clk), .rst_n(rst_n), .hit(hit), .late_zone(beyond),
    .no_retry(cfg_no_retry), .clear(finish), .cnt_now(cnt_now),
    .exc_now(exc_now), .late_now(late_now), .retry_now(retry_now)
  );

  always_comb begin
    ev            = '0;
    ev[STK_VLAN]  = vlan;
    ev[STK_UND]   = underflow;
    ev[STK_JAB]   = jabber;
    ev[STK_FLUSH] = flush;
    ev[STK_IPE]   = ip_err;
  end

  txstat_sticky #(.N(N_STICKY)) u_stk (
    .clk(clk), .rst_n(rst_n), .active(active_q), .clear(finish),
    .ev(ev), .seen_now(seen)
  );

  txstat_carrier u_crs (
    .clk(clk), .rst_n(rst_n), .active(active_q), .clear(finish),
    .crs(crs), .seen_now(crs_seen), .drop_now(crs_drop)
  );

  always_comb begin
    fld.cc    = cnt_now;
    fld.vlan  = seen[STK_VLAN];
    fld.exc   = exc_now;
    fld.late  = late_now && !seen[STK_UND];
    fld.nocrs = !crs_seen;
    fld.loss  = crs_drop && cfg_half_duplex && (cnt_now == '0);
    fld.ipe   = seen[STK_IPE];
    fld.flush = seen[STK_FLUSH];
    fld.jab   = seen[STK_JAB] && !cfg_jabber_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_o    <= 1'b0;
      abort_o    <= 1'b0;
      stat_valid <= 1'b0;
      stat_word  <= '0;
    end else begin
      retry_o    <= retry_now;
      abort_o    <= abort_now;
      stat_valid <= finish;
      if (finish) stat_word <= pack_status(fld);
    end
  end

endmodule

// File: rtl/txstat_checker.sv
module txstat_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       retry_o,
  input logic       abort_o,
  input logic       stat_valid,
  input logic       cfg_half_duplex,
  input logic       cfg_no_retry,
  input logic       cfg_jabber_off,
  input logic [3:0] cc,
  input logic       exc,
  input logic       late,
  input logic       nocrs,
  input logic       loss,
  input logic       jab,
  input logic [3:0] rsv
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> rsv == 4'd0);
  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);
  assert_full_duplex_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !$past(cfg_half_duplex)) |-> (cc == 4'd0 && !exc && !late));
  assert_retry_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> (!abort_o && !stat_valid));
  assert_abort_reports_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> stat_valid);
  assert_no_retry_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && exc && $past(cfg_no_retry)) |-> cc == 4'd1);
  assert_exc_late_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> !(exc && late));
  assert_loss_needs_carrier_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && loss) |-> (cc == 4'd0 && !nocrs));
  assert_jabber_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && $past(cfg_jabber_off)) |-> !jab);
endmodule

bind txstat_tracker txstat_checker u_chk (
  .clk(clk), .rst_n(rst_n), .retry_o(retry_o), .abort_o(abort_o),
  .stat_valid(stat_valid), .cfg_half_duplex(cfg_half_duplex),
  .cfg_no_retry(cfg_no_retry), .cfg_jabber_off(cfg_jabber_off),
  .cc(stat_word[6:3]), .exc(stat_word[8]), .late(stat_word[9]),
  .nocrs(stat_word[10]), .loss(stat_word[11]), .jab(stat_word[14]),
  .rsv({stat_word[15], stat_word[2:0]})
);

// File: tb/sim_txstat_tracker.sv
`timescale 1ns/1ps
module sim_txstat_tracker;
  localparam int LIM = 16;
  localparam int WIN = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_start = 0, tx_end = 0, byte_tick = 0, coll = 0, crs = 0;
  logic underflow = 0, jabber = 0, vlan = 0, flush = 0, ip_err = 0;
  logic cfg_half_duplex = 1, cfg_no_retry = 0, cfg_jabber_off = 0;
  logic retry_o, abort_o, stat_valid;
  logic [15:0] stat_word;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  txstat_tracker #(.ATTEMPT_LIMIT(LIM), .WINDOW_BYTES(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_end(tx_end),
    .byte_tick(byte_tick), .coll(coll), .crs(crs), .underflow(underflow),
    .jabber(jabber), .vlan(vlan), .flush(flush), .ip_err(ip_err),
    .cfg_half_duplex(cfg_half_duplex), .cfg_no_retry(cfg_no_retry),
    .cfg_jabber_off(cfg_jabber_off), .retry_o(retry_o), .abort_o(abort_o),
    .stat_word(stat_word), .stat_valid(stat_valid)
  );

  typedef struct {
    string tag;
    int    ncoll, cpos, late_at, cmode;
    bit    late, half, nr, jo, und, jab, vl, fl, ie, mid, both;
  } frame_t;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drop_pulses();
    tx_start = 0; tx_end = 0; coll = 0; underflow = 0; jabber = 0;
    vlan = 0; flush = 0; ip_err = 0; byte_tick = 0; crs = 0;
  endtask

  function automatic frame_t base(input string tag);
    frame_t f;
    f.tag = tag; f.ncoll = 0; f.cpos = 2; f.late_at = WIN; f.cmode = 1;
    f.late = 0; f.half = 1; f.nr = 0; f.jo = 0; f.und = 0; f.jab = 0;
    f.vl = 0; f.fl = 0; f.ie = 0; f.mid = 0; f.both = 0;
    return f;
  endfunction

  function automatic logic [15:0] expect_word(input frame_t f, input int cnt,
                                              input bit exc, input bit lt);
    logic [15:0] w = '0;
    w[6:3] = f.half ? cnt[3:0] : 4'd0;
    w[7]   = f.vl;
    w[8]   = exc;
    w[9]   = lt && !f.und;
    w[10]  = (f.cmode == 0);
    w[11]  = f.half && (cnt == 0) && (f.cmode == 2);
    w[12]  = f.ie;
    w[13]  = f.fl;
    w[14]  = f.jab && !f.jo;
    return w;
  endfunction

  task automatic run_frame(input frame_t f);
    int cnt = 0, att = 0;
    bit fin = 0, exc = 0, lt = 0;
    cfg_half_duplex = f.half; cfg_no_retry = f.nr; cfg_jabber_off = f.jo;
    while (!fin) begin
      bit att_over = 0;
      tx_start = 1; step(); tx_start = 0;
      chk("R3", {29'd0, retry_o, abort_o, stat_valid}, 32'd0, "outputs after start");
      for (int j = 0; !fin && !att_over; j++) begin
        bit ev_coll = 0, ev_late = 0, ev_end = 0;
        int end_j = f.late ? f.late_at + 2 : f.cpos + 3;
        byte_tick = 1;
        crs = (f.cmode == 1) || (f.cmode == 2 && j == 0);
        if (j == 0) begin
          vlan = f.vl; underflow = f.und; jabber = f.jab; flush = f.fl; ip_err = f.ie;
        end
        if (f.mid && j == 1 && att >= f.ncoll) tx_start = 1;
        if (att < f.ncoll && j == f.cpos) begin
          coll = 1; ev_coll = 1;
          if (f.both) begin tx_end = 1; ev_end = 1; end
        end else if (att >= f.ncoll && f.late && j == f.late_at) begin
          coll = 1; ev_coll = 1; ev_late = 1;
        end else if (j == end_j) begin
          tx_end = 1; ev_end = 1;
        end
        step();
        drop_pulses();
        if (ev_coll && f.half) begin
          cnt = (cnt < 15) ? cnt + 1 : 15;
          if (ev_late) begin
            lt = 1; fin = 1;
            chk("R6", {29'd0, retry_o, abort_o, stat_valid}, 32'b011, "late abort");
          end else begin
            att++;
            if (f.nr || att >= LIM) begin
              exc = 1; fin = 1;
              chk(f.nr ? "R5" : "R4", {29'd0, retry_o, abort_o, stat_valid}, 32'b011, "give-up");
            end else begin
              att_over = 1;
              chk("R3", {29'd0, retry_o, abort_o, stat_valid}, 32'b100, "retry pulse");
            end
          end
        end else if (ev_end) begin
          fin = 1;
          chk("R1", {29'd0, retry_o, abort_o, stat_valid}, 32'b001, "frame end");
        end else begin
          chk("R2", {29'd0, retry_o, abort_o, stat_valid}, 32'd0, "quiet cycle");
        end
      end
    end
    chk(f.tag, {16'd0, stat_word}, {16'd0, expect_word(f, cnt, exc, lt)}, "status word");
    // inactive cycle with stray inputs: must be ignored (R12), valid must drop (R1)
    coll = 1; tx_end = 1; vlan = 1; flush = 1; crs = 1; byte_tick = 1; jabber = 1;
    step();
    drop_pulses();
    chk("R12", {29'd0, retry_o, abort_o, stat_valid}, 32'd0, "idle stray inputs");
  endtask

  initial begin
    frame_t f;
    void'($urandom(32'h1D5EED));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    step();
    chk("R1", {13'd0, retry_o, abort_o, stat_valid, stat_word}, 32'd0, "reset state");

    f = base("R1");  run_frame(f);
    f = base("R3");  f.ncoll = 3; run_frame(f);
    f = base("R4");  f.ncoll = 17; run_frame(f);
    f = base("R2");  f.ncoll = 15; run_frame(f);
    f = base("R5");  f.ncoll = 2; f.nr = 1; run_frame(f);
    f = base("R6");  f.late = 1; run_frame(f);
    f = base("R6");  f.ncoll = 1; f.cpos = WIN - 1; run_frame(f);
    f = base("R12"); f.late = 1; f.mid = 1; f.ncoll = 2; run_frame(f);
    f = base("R7");  f.late = 1; f.und = 1; run_frame(f);
    f = base("R8");  f.cmode = 0; run_frame(f);
    f = base("R9");  f.cmode = 2; run_frame(f);
    f = base("R9");  f.cmode = 2; f.ncoll = 1; run_frame(f);
    f = base("R10"); f.jab = 1; run_frame(f);
    f = base("R10"); f.jab = 1; f.jo = 1; run_frame(f);
    f = base("R11"); f.vl = 1; f.fl = 1; f.ie = 1; run_frame(f);
    f = base("R2");  f.half = 0; f.ncoll = 3; f.cmode = 2; run_frame(f);
    f = base("R13"); f.ncoll = 2; f.both = 1; run_frame(f);

    for (int n = 0; n < 300; n++) begin
      int r;
      f = base("R1");
      f.half = ($urandom % 4) != 0;
      f.nr   = ($urandom % 5) == 0;
      f.jo   = $urandom % 2;
      r = $urandom % 10;
      f.ncoll = (r < 5) ? 0 : (r < 8) ? 1 + $urandom % 4 : 14 + $urandom % 4;
      f.cpos    = ($urandom % 2) ? 2 : WIN - 1;
      f.late    = ($urandom % 4) == 0;
      f.late_at = WIN + $urandom % 3;
      f.cmode   = $urandom % 3;
      f.und = $urandom % 2; f.jab = $urandom % 2; f.vl = $urandom % 2;
      f.fl  = $urandom % 2; f.ie  = $urandom % 2;
      f.mid  = f.late && ($urandom % 2);
      f.both = ($urandom % 4) == 0;
      run_frame(f);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule